// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table held in memory. A request carries the virtual address, whether the access is a write, and whether it comes from user mode. The walker samples the directory base register when it accepts the request. It then fetches one 32-bit word from the directory page. If that entry maps a large page, the walk ends there. Otherwise the walker fetches a second word from the page table that the entry points to.

A successful walk returns the physical address together with the combined write and user permissions of the levels it used. A failed walk returns a three-bit fault code instead. After a successful walk, the walker writes back any entry whose accessed bit was clear, and on a write it marks the leaf entry dirty. All memory traffic goes through one word-wide request/acknowledge port. Only one translation is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to address {base[31:12], va[31:22], 2'b00}, where base is dir_base_i sampled when the request is accepted.
- R2: For a small page, the second read goes to {dir[31:12], va[21:12], 2'b00} and the physical address is {leaf[31:12], va[11:0]}.
- R3: A present directory entry with bit 7 set maps a 4 MB page. The physical address is {dir[31:22], va[21:0]} and no second read is issued.
- R4: An entry with bit 0 clear at either level ends the walk with a fault whose code bit 0 is 0, and nothing is written to memory.
- R5: A user access faults with code bit 0 set when either level has bit 2 clear. A user write also faults this way when either level has bit 1 clear.
- R6: A supervisor access never takes a protection fault. A supervisor write to a page whose bit 1 is clear completes normally.
- R7: The fault code is {user, write, protection}: bit 2 is set for a user access, bit 1 for a write, and bit 0 for a protection fault.
- R8: Entry bits 11..9 affect neither the outcome nor the permissions, and any write-back keeps them unchanged.
- R9: After a successful walk, each entry used that had bit 5 clear is written back with bit 5 set. The leaf is written first, then the directory entry. All other bits stay as they were, and an entry that needs no change is not written.
- R10: A successful write access also sets bit 6 of the leaf entry. For a large page, the leaf is the directory entry.
- R11: busy_o rises in the cycle after a request is accepted and stays high through the done cycle. Requests made while busy_o is high are ignored. When idle, the walker issues no memory request.
- R12: Once mem_req_o is raised, it stays high with the same address, write flag and data until mem_ack_i is seen.
- R13: done_o is a single-cycle pulse. On success, perm_rw_o and perm_us_o are the AND of bit 1 and bit 2 over the levels used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is from user mode |
| dir_base_i | input | 32 | Directory page base, bits 31..12 used |
| busy_o | output | 1 | Walk in progress, new requests blocked |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Word address of memory access |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory access completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| done_o | output | 1 | Result valid pulse |
| fault_o | output | 1 | Walk ended in a fault |
| fault_code_o | output | 3 | Fault code {user, write, protection} |
| paddr_o | output | 32 | Physical address |
| perm_rw_o | output | 1 | Combined write permission |
| perm_us_o | output | 1 | Combined user permission |

## Verification
The hardest situation to reach is a walk where permissions, large-page decoding and write-back all interact. One example is a user write through a large-page entry whose accessed and dirty bits are both clear. Another is a leaf whose bits differ from the directory entry only in bit 1 or bit 2, while the other level is fully permissive. The stimulus builds fresh directory and table entries in the bench memory for every walk. It chooses the present, large-page, permission, status and ignored bits at random, and the acknowledge arrives after a random delay. Directed walks pin down each fault type and the case where nothing needs writing back. While each walk is running, the bench keeps presenting a different request to confirm that it is ignored.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int PTE_W     = 32;
  localparam int OFS_W     = 12;
  localparam int TBL_IDX_W = 10;
  localparam int DIR_IDX_W = 10;
  localparam int ENT_LSB   = 2;
  localparam int LG_OFS_W  = OFS_W + TBL_IDX_W;
  localparam int FC_W      = 3;

  localparam int BIT_P   = 0;
  localparam int BIT_RW  = 1;
  localparam int BIT_US  = 2;
  localparam int BIT_ACC = 5;
  localparam int BIT_DRT = 6;
  localparam int BIT_LG  = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_RD_TBL, ST_EVAL, ST_WB_LEAF, ST_WB_DIR, ST_RESP
  } walk_st_e;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
  import pt_walker_pkg::*;
(
  input  logic [PTE_W-1:0] base_i,
  input  logic [PTE_W-1:0] va_i,
  input  logic [PTE_W-1:0] dir_e_i,
  input  logic [PTE_W-1:0] leaf_e_i,
  input  logic             large_i,
  output logic [PTE_W-1:0] dir_addr_o,
  output logic [PTE_W-1:0] tbl_addr_o,
  output logic [PTE_W-1:0] paddr_o
);
  assign dir_addr_o = {base_i[PTE_W-1:OFS_W], va_i[PTE_W-1 -: DIR_IDX_W], {ENT_LSB{1'b0}}};
  assign tbl_addr_o = {dir_e_i[PTE_W-1:OFS_W], va_i[LG_OFS_W-1:OFS_W], {ENT_LSB{1'b0}}};
  assign paddr_o = large_i ? {leaf_e_i[PTE_W-1:LG_OFS_W], va_i[LG_OFS_W-1:0]}
                           : {leaf_e_i[PTE_W-1:OFS_W], va_i[OFS_W-1:0]};
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_walker_pkg::*;
(
  input  logic [PTE_W-1:0] dir_e_i,
  input  logic [PTE_W-1:0] leaf_e_i,
  input  logic             write_i,
  input  logic             user_i,
  output logic             eff_rw_o,
  output logic             eff_us_o,
  output logic             prot_o
);
  assign eff_rw_o = dir_e_i[BIT_RW] & leaf_e_i[BIT_RW];
  assign eff_us_o = dir_e_i[BIT_US] & leaf_e_i[BIT_US];
  // supervisor bypasses both checks
  assign prot_o = user_i & (~eff_us_o | (write_i & ~eff_rw_o));
endmodule

// File: rtl/pt_bit_update.sv
module pt_bit_update
  import pt_walker_pkg::*;
(
  input  logic [PTE_W-1:0] entry_i,
  input  logic             set_dirty_i,
  output logic [PTE_W-1:0] entry_o,
  output logic             need_wb_o
);
  always_comb begin
    entry_o = entry_i;
    entry_o[BIT_ACC] = 1'b1;
    if (set_dirty_i) entry_o[BIT_DRT] = 1'b1;
  end
  assign need_wb_o = (entry_o != entry_i);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [PTE_W-1:0] req_vaddr_i,
  input  logic             req_write_i,
  input  logic             req_user_i,
  input  logic [PTE_W-1:0] dir_base_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PTE_W-1:0] mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [FC_W-1:0]  fault_code_o,
  output logic [PTE_W-1:0] paddr_o,
  output logic             perm_rw_o,
  output logic             perm_us_o
);
  walk_st_e         st_q;
  logic [PTE_W-1:0] va_q, base_q, dir_q, leaf_q, leaf_addr_q, pa_q;
  logic             wr_q, usr_q, large_q, fault_q, rw_q, us_q;
  logic [FC_W-1:0]  code_q;

  logic [PTE_W-1:0] dir_addr, tbl_addr, pa_calc, dir_new, leaf_new;
  logic             eff_rw, eff_us, prot, dir_wb, leaf_wb;

  pt_addr_gen u_addr (
    .base_i(base_q), .va_i(va_q), .dir_e_i(dir_q), .leaf_e_i(leaf_q),
    .large_i(large_q), .dir_addr_o(dir_addr), .tbl_addr_o(tbl_addr), .paddr_o(pa_calc)
  );

  pt_perm_check u_perm (
    .dir_e_i(dir_q), .leaf_e_i(leaf_q), .write_i(wr_q), .user_i(usr_q),
    .eff_rw_o(eff_rw), .eff_us_o(eff_us), .prot_o(prot)
  );

  pt_bit_update u_upd_dir (
    .entry_i(dir_q), .set_dirty_i(1'b0), .entry_o(dir_new), .need_wb_o(dir_wb)
  );

  pt_bit_update u_upd_leaf (
    .entry_i(leaf_q), .set_dirty_i(wr_q), .entry_o(leaf_new), .need_wb_o(leaf_wb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      dir_q       <= '0;
      leaf_q      <= '0;
      leaf_addr_q <= '0;
      pa_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      large_q     <= 1'b0;
      fault_q     <= 1'b0;
      rw_q        <= 1'b0;
      us_q        <= 1'b0;
      code_q      <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_vaddr_i;
          base_q  <= dir_base_i;
          wr_q    <= req_write_i;
          usr_q   <= req_user_i;
          large_q <= 1'b0;
          fault_q <= 1'b0;
          code_q  <= '0;
          st_q    <= ST_RD_DIR;
        end
        ST_RD_DIR: if (mem_ack_i) begin
          dir_q <= mem_rdata_i;
          if (!mem_rdata_i[BIT_P]) begin
            fault_q <= 1'b1;
            code_q  <= {usr_q, wr_q, 1'b0};
            st_q    <= ST_RESP;
          end else if (mem_rdata_i[BIT_LG]) begin
            leaf_q      <= mem_rdata_i;
            leaf_addr_q <= dir_addr;
            large_q     <= 1'b1;
            st_q        <= ST_EVAL;
          end else begin
            st_q <= ST_RD_TBL;
          end
        end
        ST_RD_TBL: if (mem_ack_i) begin
          leaf_q      <= mem_rdata_i;
          leaf_addr_q <= tbl_addr;
          if (!mem_rdata_i[BIT_P]) begin
            fault_q <= 1'b1;
            code_q  <= {usr_q, wr_q, 1'b0};
            st_q    <= ST_RESP;
          end else begin
            st_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (prot) begin
            fault_q <= 1'b1;
            code_q  <= {usr_q, wr_q, 1'b1};
            st_q    <= ST_RESP;
          end else begin
            pa_q <= pa_calc;
            rw_q <= eff_rw;
            us_q <= eff_us;
            if (leaf_wb)                 st_q <= ST_WB_LEAF;
            else if (!large_q && dir_wb) st_q <= ST_WB_DIR;
            else                         st_q <= ST_RESP;
          end
        end
        ST_WB_LEAF: if (mem_ack_i) begin
          st_q <= (!large_q && dir_wb) ? ST_WB_DIR : ST_RESP;
        end
        ST_WB_DIR: if (mem_ack_i) st_q <= ST_RESP;
        ST_RESP:   st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_RD_DIR:  begin mem_req_o = 1'b1; mem_addr_o = dir_addr; end
      ST_RD_TBL:  begin mem_req_o = 1'b1; mem_addr_o = tbl_addr; end
      ST_WB_LEAF: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = leaf_addr_q; mem_wdata_o = leaf_new;
      end
      ST_WB_DIR:  begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = dir_addr; mem_wdata_o = dir_new;
      end
      default: ;
    endcase
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_RESP);
  assign fault_o      = fault_q;
  assign fault_code_o = code_q;
  assign paddr_o      = pa_q;
  assign perm_rw_o    = rw_q;
  assign perm_us_o    = us_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_walker_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [PTE_W-1:0] req_vaddr_i,
  input logic             req_write_i,
  input logic             req_user_i,
  input logic             busy_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [PTE_W-1:0] mem_addr_o,
  input logic [PTE_W-1:0] mem_wdata_o,
  input logic             mem_ack_i,
  input logic             done_o,
  input logic             fault_o,
  input logic [FC_W-1:0]  fault_code_o,
  input logic [PTE_W-1:0] paddr_o
);
  logic [PTE_W-1:0] va_c;
  logic             wr_c, usr_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_c  <= '0;
      wr_c  <= 1'b0;
      usr_c <= 1'b0;
    end else if (req_valid_i && !busy_o) begin
      va_c  <= req_vaddr_i;
      wr_c  <= req_write_i;
      usr_c <= req_user_i;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |=> busy_o); // R11
  AST_IDLE_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R11
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
      && $stable(mem_wdata_o)); // R12
  AST_WB_ACCESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[BIT_ACC]); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R13
  AST_SUP_NO_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o && !usr_c |-> !fault_code_o[0]); // R6
  AST_CODE_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> fault_code_o[2:1] == {usr_c, wr_c}); // R7
  AST_PAGE_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> paddr_o[OFS_W-1:0] == va_c[OFS_W-1:0]); // R2
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i),
  .req_write_i(req_write_i), .req_user_i(req_user_i), .busy_o(busy_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .done_o(done_o),
  .fault_o(fault_o), .fault_code_o(fault_code_o), .paddr_o(paddr_o)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0010_0000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        busy_o, mem_req_o, mem_we_o, done_o, fault_o, perm_rw_o, perm_us_o;
  logic [31:0] mem_addr_o, mem_wdata_o, paddr_o;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [2:0]  fault_code_o;

  pt_walker u_pt_walker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .req_user_i(req_user), .dir_base_i(BASE), .busy_o(busy_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .done_o(done_o), .fault_o(fault_o), .fault_code_o(fault_code_o), .paddr_o(paddr_o),
    .perm_rw_o(perm_rw_o), .perm_us_o(perm_us_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [logic [31:0]];
  int rd_n = 0, wr_n = 0, hold_viol = 0;
  logic [31:0] rd_log [4];
  logic pend = 1'b0;
  logic [31:0] pend_addr = '0;

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: random-latency acknowledge, acts at negedge
  always @(negedge clk) begin
    if (pend && mem_req_o && mem_addr_o != pend_addr) hold_viol++;
    mem_ack   = mem_req_o && ($urandom % 2 == 0);
    mem_rdata = mem_req_o ? rd_mem(mem_addr_o) : 32'h0;
    if (mem_req_o && mem_ack) begin
      if (mem_we_o) begin
        mem[mem_addr_o] = mem_wdata_o;
        wr_n++;
      end else begin
        if (rd_n < 4) rd_log[rd_n] = mem_addr_o;
        rd_n++;
      end
    end
    pend      = mem_req_o && !mem_ack;
    pend_addr = mem_addr_o;
  end

  // expected results
  logic        e_fault, e_rw, e_us, e_large;
  logic [2:0]  e_code;
  logic [31:0] e_pa, e_dir, e_leaf, e_daddr, e_laddr;
  int          e_reads, e_writes;

  task automatic model(input logic [31:0] va, input logic w, input logic u);
    logic [31:0] d, l;
    logic prot;
    e_daddr = {BASE[31:12], va[31:22], 2'b00};
    d = rd_mem(e_daddr);
    e_dir = d; e_fault = 1'b0; e_code = 3'b000; e_large = 1'b0;
    e_writes = 0; e_pa = '0; e_rw = 1'b0; e_us = 1'b0;
    e_laddr = e_daddr; l = d; e_reads = 1;
    if (!d[0]) begin
      e_fault = 1'b1; e_code = {u, w, 1'b0};
    end else if (d[7]) begin
      e_large = 1'b1;
    end else begin
      e_laddr = {d[31:12], va[21:12], 2'b00};
      l = rd_mem(e_laddr);
      e_reads = 2;
      if (!l[0]) begin e_fault = 1'b1; e_code = {u, w, 1'b0}; end
    end
    e_leaf = l;
    if (!e_fault) begin
      e_rw = d[1] & l[1];
      e_us = d[2] & l[2];
      prot = u & (!e_us | (w & !e_rw));
      if (prot) begin
        e_fault = 1'b1; e_code = {u, w, 1'b1};
      end else begin
        e_pa = e_large ? {l[31:22], va[21:0]} : {l[31:12], va[11:0]};
        e_leaf = l | 32'h20 | (w ? 32'h40 : 32'h0);
        if (e_leaf != l) e_writes++;
        if (e_large) e_dir = e_leaf;
        else begin
          e_dir = d | 32'h20;
          if (e_dir != d) e_writes++;
        end
      end
    end
  endtask

  task automatic set_walk(input logic [31:0] va, input logic [31:0] d, input logic [31:0] l);
    mem[{BASE[31:12], va[31:22], 2'b00}] = d;
    if (d[0] && !d[7]) mem[{d[31:12], va[21:12], 2'b00}] = l;
  endtask

  task automatic run_walk(input logic [31:0] va, input logic w, input logic u);
    int guard;
    model(va, w, u);
    rd_n = 0; wr_n = 0;
    req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u;
    @(negedge clk);
    chk("R11 busy after accept", 32'(busy_o), 32'd1);
    // a different request held while busy must be ignored
    req_vaddr = ~va; req_write = ~w; req_user = ~u;
    guard = 0;
    while (!done_o && guard < 200) begin @(negedge clk); guard++; end
    if (!done_o) begin
      n_chk++; n_bad++;
      $display("FAIL R13 walk timeout: actual no done expected done");
    end
    req_valid = 1'b0;
    chk("R4 R5 fault flag", 32'(fault_o), 32'(e_fault));
    if (e_fault) chk("R7 fault code", 32'(fault_code_o), 32'(e_code));
    else begin
      chk("R2 R3 physical address", paddr_o, e_pa);
      chk("R13 R6 permissions", {30'd0, perm_rw_o, perm_us_o}, {30'd0, e_rw, e_us});
    end
    chk("R1 directory read address", rd_log[0], e_daddr);
    if (e_reads == 2) chk("R2 table read address", rd_log[1], e_laddr);
    chk("R3 read count", 32'(rd_n), 32'(e_reads));
    chk("R9 R4 write count", 32'(wr_n), 32'(e_writes));
    chk("R9 R10 R8 leaf entry", rd_mem(e_laddr), e_leaf);
    chk("R9 directory entry", rd_mem(e_daddr), e_dir);
    @(negedge clk);
    chk("R13 done pulse", 32'(done_o), 32'd0);
    chk("R11 idle after done", {30'd0, busy_o, mem_req_o}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, l, va;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R11 reset busy", 32'(busy_o), 32'd0);
    chk("R13 reset done", 32'(done_o), 32'd0);
    chk("R12 reset mem request", 32'(mem_req_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    va = 32'h1234_5678;
    set_walk(va, 32'h0023_4007, 32'h0ABC_D007); run_walk(va, 1'b0, 1'b1); // R1 R2 R9
    set_walk(va, 32'h0023_4007, 32'h0ABC_D007); run_walk(va, 1'b1, 1'b1); // R10
    set_walk(va, 32'h0C80_0087, 32'h0);         run_walk(va, 1'b1, 1'b1); // R3
    set_walk(va, 32'h0023_4006, 32'h0);         run_walk(va, 1'b1, 1'b0); // R4 dir
    set_walk(va, 32'h0023_4007, 32'h0ABC_D006); run_walk(va, 1'b0, 1'b1); // R4 leaf
    set_walk(va, 32'h0023_4007, 32'h0ABC_D005); run_walk(va, 1'b1, 1'b1); // R5 R7 111
    set_walk(va, 32'h0023_4003, 32'h0ABC_D007); run_walk(va, 1'b0, 1'b1); // R5 R7 101
    set_walk(va, 32'h0023_4001, 32'h0ABC_D001); run_walk(va, 1'b1, 1'b0); // R6
    set_walk(va, 32'h0023_4E27, 32'h0ABC_DE67); run_walk(va, 1'b1, 1'b1); // R8 no writes
    set_walk(va, 32'h0C80_0E81, 32'h0);         run_walk(va, 1'b1, 1'b0); // R3 R6 R10 large

    for (int i = 0; i < 400; i++) begin
      va = $urandom;
      d = $urandom;
      d[0] = ($urandom % 10) != 0;
      d[7] = ($urandom % 3) == 0;
      if (!d[7]) d[31:12] = {12'h002, 8'($urandom)};
      l = $urandom;
      l[0] = ($urandom % 10) != 0;
      set_walk(va, d, l);
      run_walk(va, 1'($urandom), 1'($urandom));
    end

    chk("R12 request held until acknowledge", 32'(hold_viol), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule